// File: doc/BRIEF.md
# Programmable-Modulus Phase Accumulator Oscillator

This block is a numerically controlled square-wave oscillator. A 32-bit phase register advances by a programmed step on every enabled clock. One output, the square wave, is decoded from the phase, and a second output pulses each time the phase wraps. The output frequency is `f_clk * step / modulus`. Output edges fall only on clock edges, so every edge carries up to one clock period of timing uncertainty. The block makes no attempt to remove it.

There are two modes. In binary mode the modulus is 2^32 and the square wave is the top phase bit. In decimal mode the modulus is a programmed value, so integer steps give exact decimal frequency increments. For example, a modulus of 840,000,000 on an 84 MHz clock gives 0.1 Hz per step LSB, which covers 0 Hz to 10 kHz in exact 0.1 Hz steps. New step, modulus and mode values take effect only at a wrap, so a period is never cut short. Decimal-mode settings are expected to satisfy `2 <= modulus` and `step < modulus`.

Top module: `nco_osc`

## Requirements
- R1: While reset is asserted and after its release with enable low, `sq_o` and `wrap_o` are 0, the phase is 0 and the active step is zero.
- R2: With `dec_mode_i`=0 each enabled clock adds the active step to the phase modulo 2^32, and `sq_o` equals phase bit 31.
- R3: With `dec_mode_i`=1 each enabled clock adds the active step, and the active modulus is subtracted when the sum is at or above it, so the phase stays in [0, modulus).
- R4: In decimal mode `sq_o` is 1 exactly when the phase is at or above floor(modulus/2). For an odd modulus of 11 the threshold is 5.
- R5: `wrap_o` is 1 for exactly one cycle per wrap, in the cycle in which the wrapped phase first appears.
- R6: Step, modulus and mode are taken from the inputs only on an enabled clock that wraps, or on an enabled clock while the active step is zero. The clock that captures still adds the old active step. The first enabled clock after reset therefore captures and leaves the phase at 0.
- R7: While the active step is zero, the phase, `sq_o` and `wrap_o` stay constant and no wrap occurs. A nonzero step applied later is captured on the next enabled clock.
- R8: With `en_i`=0 the phase and `sq_o` hold, `wrap_o` is 0 and nothing is captured.
- R9: When a capture leaves the phase at or above a newly loaded decimal modulus, the phase restarts at 0.
- R10: With a modulus of 840,000,000, N clocks after capture produce exactly floor(N*step/840,000,000) wraps, with no drift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Advance enable |
| inc_i | input | 32 | Requested phase step |
| mod_i | input | 32 | Requested modulus (decimal mode) |
| dec_mode_i | input | 1 | 1 = programmable modulus, 0 = 2^32 |
| sq_o | output | 1 | Square-wave output |
| wrap_o | output | 1 | One-cycle strobe on each phase wrap |

## Verification
A table of settings drives the accumulation path. The table covers power-of-two steps that wrap on exact boundaries, an odd binary step that leaves a ragged remainder, small, odd and near-maximum decimal moduli, and the 0.1 Hz decimal modulus. Wrap counts separate binary carry from decimal subtraction, and the final output level tests the half-modulus threshold. Directed sequences follow. One changes the step mid-period, to tell deferred capture from immediate capture. One stops on a high level with a zero step, to tell freezing from reset-to-low. One switches from binary to decimal on a wrap with a large remainder, to show the phase restarting at zero. Enable-low and reset sequences show the state holding and clearing.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int NCO_W = 32;

    typedef struct packed {
        logic             dec;
        logic [NCO_W-1:0] modulus;
        logic [NCO_W-1:0] step;
    } nco_cfg_t;

    typedef struct packed {
        logic [NCO_W-1:0] phase;
        logic             wrap;
    } nco_acc_t;

endpackage

// File: rtl/nco_cfg_shadow.sv
module nco_cfg_shadow
    import nco_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  nco_cfg_t cfg_new_i,
    output nco_cfg_t cfg_act_o
);

    nco_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d = cfg_new_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_act_o = cfg_q;

    // R6: the active settings change only on a capture
    a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(cfg_q));

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
    import nco_pkg::*;
#(
    parameter int W = NCO_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  nco_cfg_t     cfg_act_i,
    input  nco_cfg_t     cfg_new_i,
    output logic [W-1:0] phase_o,
    output logic         wrap_o,
    output logic         load_o
);

    localparam int SW = W + 1;

    nco_acc_t         st_d, st_q;
    logic [SW-1:0]    sum_w;
    logic [SW-1:0]    mod_w;
    logic             over;
    logic [W-1:0]     rem;
    logic             step_zero;
    logic             load;

    always_comb begin
        sum_w     = {1'b0, st_q.phase} + {1'b0, cfg_act_i.step};
        mod_w     = {1'b0, cfg_act_i.modulus};
        step_zero = (cfg_act_i.step == '0);
        if (cfg_act_i.dec) begin
            over = (sum_w >= mod_w);
            rem  = over ? W'(sum_w - mod_w) : sum_w[W-1:0];
        end else begin
            over = sum_w[W];
            rem  = sum_w[W-1:0];
        end
        load = en_i && (over || step_zero);

        st_d      = st_q;
        st_d.wrap = 1'b0;
        if (en_i) begin
            st_d.wrap  = over;
            st_d.phase = rem;
            if (load && cfg_new_i.dec && (rem >= cfg_new_i.modulus)) begin
                st_d.phase = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign wrap_o  = st_q.wrap;
    assign load_o  = load;

    // R8: a disabled clock leaves the phase alone and raises no strobe
    a_r8_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(st_q.phase) && !st_q.wrap));

    // R3: with legal decimal settings the phase never reaches the modulus
    a_r3_phase_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_act_i.dec && (cfg_act_i.modulus >= W'(2)) &&
         (cfg_act_i.step < cfg_act_i.modulus)) |-> (st_q.phase < cfg_act_i.modulus));

    // R2: in binary mode a wrap is exactly a drop in phase
    a_r2_bin_wrap_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !cfg_act_i.dec && !load) |=> (st_q.wrap == (st_q.phase < $past(st_q.phase))));

    // R5: a strobe only follows an enabled clock
    a_r5_wrap_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wrap |-> $past(en_i));

endmodule

// File: rtl/nco_sq_decode.sv
module nco_sq_decode
    import nco_pkg::*;
#(
    parameter int W = NCO_W
) (
    input  logic [W-1:0] phase_i,
    input  nco_cfg_t     cfg_act_i,
    output logic         sq_o
);

    logic [W-1:0] half;

    always_comb begin
        half = cfg_act_i.modulus >> 1;
        if (cfg_act_i.dec) begin
            sq_o = (phase_i >= half);
        end else begin
            sq_o = phase_i[W-1];
        end
    end

endmodule

// File: rtl/nco_osc.sv
module nco_osc
    import nco_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [NCO_W-1:0] inc_i,
    input  logic [NCO_W-1:0] mod_i,
    input  logic             dec_mode_i,
    output logic             sq_o,
    output logic             wrap_o
);

    nco_cfg_t         cfg_new;
    nco_cfg_t         cfg_act;
    logic [NCO_W-1:0] phase;
    logic             load;

    always_comb begin
        cfg_new.dec     = dec_mode_i;
        cfg_new.modulus = mod_i;
        cfg_new.step    = inc_i;
    end

    nco_cfg_shadow u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .cfg_new_i (cfg_new),
        .cfg_act_o (cfg_act)
    );

    nco_phase_acc #(.W(NCO_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .cfg_act_i (cfg_act),
        .cfg_new_i (cfg_new),
        .phase_o   (phase),
        .wrap_o    (wrap_o),
        .load_o    (load)
    );

    nco_sq_decode #(.W(NCO_W)) u_dec (
        .phase_i   (phase),
        .cfg_act_i (cfg_act),
        .sq_o      (sq_o)
    );

    // R7: a zero active step with unchanged inputs keeps the output level
    a_r7_zero_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (cfg_act.step == '0) && (cfg_new == cfg_act)) |=> ($stable(sq_o) && !wrap_o));

endmodule

// File: tb/nco_osc_tb.sv
module nco_osc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en_i;
    logic [31:0] inc_i;
    logic [31:0] mod_i;
    logic        dec_mode_i;
    logic        sq_o;
    logic        wrap_o;

    int n_checks = 0;
    int n_fail   = 0;
    int wraps    = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    nco_osc dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .inc_i      (inc_i),
        .mod_i      (mod_i),
        .dec_mode_i (dec_mode_i),
        .sq_o       (sq_o),
        .wrap_o     (wrap_o)
    );

    // {dec, modulus, step, clocks}
    localparam logic [96:0] VECS [0:7] = '{
        {1'b0, 32'd0,         32'h1000_0000, 32'd40},
        {1'b0, 32'd0,         32'h3000_0001, 32'd50},
        {1'b1, 32'd1000,      32'd7,         32'd500},
        {1'b1, 32'd840000000, 32'd300000000, 32'd30},
        {1'b1, 32'd10,        32'd3,         32'd64},
        {1'b1, 32'd11,        32'd5,         32'd33},
        {1'b0, 32'd0,         32'h8000_0000, 32'd9},
        {1'b1, 32'd999,       32'd998,       32'd20}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en_i  = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (wrap_o) wraps++;
        end
    endtask

    initial begin
        rst_n = 1'b0; en_i = 1'b0; inc_i = '0; mod_i = '0; dec_mode_i = 1'b0;

        // R1 reset state
        do_reset();
        step(3);
        check(sq_o == 1'b0, "R1 sq after reset", sq_o, 0);
        check(wraps == 0, "R1 no wrap after reset", wraps, 0);

        // table walk: R2 R3 R4 R5 R10
        for (int v = 0; v < 8; v++) begin
            logic [63:0] m, prod, ph, wexp;
            logic        sexp;
            int          n;
            do_reset();
            dec_mode_i = VECS[v][96];
            mod_i      = VECS[v][95:64];
            inc_i      = VECS[v][63:32];
            n          = int'(VECS[v][31:0]);
            en_i       = 1'b1;
            wraps      = 0;
            step(n);
            m    = dec_mode_i ? 64'(mod_i) : 64'h1_0000_0000;
            prod = 64'(n - 1) * 64'(inc_i);
            wexp = prod / m;
            ph   = prod % m;
            sexp = dec_mode_i ? (ph >= (m >> 1)) : ph[31];
            check(wraps == int'(wexp), "R5/R10 wrap count", wraps, longint'(wexp));
            check(sq_o == sexp, dec_mode_i ? "R4 decimal level" : "R2 binary level", sq_o, sexp);
        end

        // R6 deferred capture of a new step
        do_reset();
        dec_mode_i = 1'b1; mod_i = 32'd100; inc_i = 32'd1; en_i = 1'b1;
        wraps = 0;
        step(11);
        inc_i = 32'd50;
        step(89);
        check(wraps == 0, "R6 old step runs out the period", wraps, 0);
        step(1);
        check(wrap_o == 1'b1, "R6 wrap with old step", wrap_o, 1);
        step(1);
        check(wrap_o == 1'b0 && sq_o == 1'b1, "R6 new step after wrap", sq_o, 1);
        step(1);
        check(wrap_o == 1'b1, "R6 second wrap with new step", wrap_o, 1);

        // R7 zero step freezes a high level
        do_reset();
        dec_mode_i = 1'b1; mod_i = 32'd10; inc_i = 32'd9; en_i = 1'b1;
        step(2);
        inc_i = 32'd0;
        step(1);
        check(wrap_o == 1'b1 && sq_o == 1'b1, "R7 wrap into frozen high", sq_o, 1);
        wraps = 0;
        step(40);
        check(wraps == 0, "R7 no wrap while frozen", wraps, 0);
        check(sq_o == 1'b1, "R7 level held", sq_o, 1);
        inc_i = 32'd3;
        step(1);
        check(wrap_o == 1'b0 && sq_o == 1'b1, "R7 capture cycle holds", sq_o, 1);
        step(1);
        check(wrap_o == 1'b1 && sq_o == 1'b0, "R7 resumes with new step", sq_o, 0);

        // R8 enable low holds and ignores new settings
        begin
            logic held;
            step(3);
            held  = sq_o;
            en_i  = 1'b0;
            inc_i = 32'd1;
            wraps = 0;
            step(20);
            check(wraps == 0, "R8 no wrap while disabled", wraps, 0);
            check(sq_o == held, "R8 level held while disabled", sq_o, held);
        end

        // R9 binary to decimal switch clamps the phase
        do_reset();
        dec_mode_i = 1'b0; mod_i = 32'd0; inc_i = 32'hC000_0000; en_i = 1'b1;
        step(2);
        dec_mode_i = 1'b1; mod_i = 32'd10; inc_i = 32'd1;
        step(1);
        check(wrap_o == 1'b1 && sq_o == 1'b0, "R9 phase restarts at zero", sq_o, 0);
        wraps = 0;
        step(9);
        check(wraps == 0, "R9 no early wrap", wraps, 0);
        step(1);
        check(wrap_o == 1'b1, "R9 wrap after full decimal period", wrap_o, 1);

        // R1 reset in mid-run
        step(4);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(sq_o == 1'b0 && wrap_o == 1'b0, "R1 mid-run reset clears", sq_o, 0);
        rst_n = 1'b1;
        en_i = 1'b0;

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule